// File: doc/BRIEF.md
# Edge-Qualified Up/Down Event Counter

This block keeps a signed event total. Two level inputs, one for counting up and one for counting down, are sampled on every clock. Internally the block turns each low-to-high change into a single count event. A level that stays high counts only once, so a signal that stays asserted for many cycles adds one step and no more. Two control inputs take precedence over counting. A clear input returns the total to zero, and a load input copies a signed preset value into the total.

Two flag outputs compare the running total against fixed limits. The first flag is high while the total is at or above the preset. The second flag is high while the total is zero or negative. The flags are plain comparisons of the current total, not one-cycle carry or borrow pulses. Because the total is signed, it can go below zero. It saturates at both ends of its range and never wraps. The block is used to count discrete process events such as parts passing a sensor, with the preset acting as a batch target.

Top module: `updown_event_counter`

## Requirements
- R1: When `clr` is 1 at a clock edge, `count` is 0 after that edge, regardless of `load`, `preset` and the count inputs.
- R2: When `load` is 1 and `clr` is 0 at a clock edge, `count` takes the value of `preset` after that edge, and any count edges in that cycle are ignored.
- R3: A clock edge at which `cnt_up` is 1 after being 0 at the previous edge increases `count` by exactly one. If `cnt_up` stays 1, it adds nothing more until it has been 0 for at least one edge.
- R4: A clock edge at which `cnt_dn` is 1 after being 0 at the previous edge decreases `count` by exactly one, with the same once-per-pulse rule as R3.
- R5: When rising changes on `cnt_up` and `cnt_dn` fall on the same edge, and neither `clr` nor `load` is set, `count` is unchanged.
- R6: `at_preset` is 1 exactly when `count` is greater than or equal to `preset`, with both values compared as signed two's-complement numbers.
- R7: `at_floor` is 1 exactly when `count` is zero or negative, treating `count` as signed.
- R8: A count-up event at the largest positive value leaves `count` at that value. A count-down event at the most negative value leaves `count` at that value.
- R9: After `rst_n` is asserted, `count` is 0. A count input that is already 1 when reset is released produces no count until it has gone to 0 and back to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the total to zero (highest priority) |
| load | input | 1 | Synchronous copy of `preset` into the total |
| cnt_up | input | 1 | Up-count level; each low-to-high change counts once |
| cnt_dn | input | 1 | Down-count level; each low-to-high change counts once |
| preset | input | CNT_W | Signed preset value |
| count | output | CNT_W | Signed running total |
| at_preset | output | 1 | High while the total is at or above the preset |
| at_floor | output | 1 | High while the total is zero or negative |

## Verification
The bench builds the counter with `CNT_W` set to 4, which gives a signed range of -8 to 7. At that width a load followed by one or two pulses reaches both saturation limits, and the preset comparison can be tested with negative values next to the most negative count. The default width of 16 bits is only elaborated, not exercised. The directed scenarios cover held levels, simultaneous edges, and both control inputs, including clear and load asserted together.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_INC   = 2'd1,
      OP_DEC   = 2'd2
   } evctr_op_e;

   localparam int unsigned CH_UP = 0;
   localparam int unsigned CH_DN = 1;
   localparam int unsigned N_CH  = 2;
endpackage

// File: rtl/evctr_edge.sv
module evctr_edge #(
   parameter int unsigned N_IN = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] lvl,
   output logic [N_IN-1:0] rise
);
   if (N_IN < 1) begin : g_chk
      $error("evctr_edge: N_IN must be at least 1");
   end

   for (genvar i = 0; i < N_IN; i++) begin : g_ch
      logic prev_q;
      // Reset high so a level already asserted at release is not a new event.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b1;
         else        prev_q <= lvl[i];
      end
      assign rise[i] = lvl[i] & ~prev_q;

      p_single_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
         rise[i] |=> !rise[i]);
   end
endmodule

// File: rtl/evctr_step.sv
module evctr_step
   import evctr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic [CNT_W-1:0] cur,
   input  evctr_op_e        op,
   output logic [CNT_W-1:0] nxt
);
   localparam logic [CNT_W-1:0] MAX_V = {1'b0, {(CNT_W-1){1'b1}}};
   localparam logic [CNT_W-1:0] MIN_V = {1'b1, {(CNT_W-1){1'b0}}};
   localparam logic [CNT_W-1:0] ONE_V = {{(CNT_W-1){1'b0}}, 1'b1};

   always_comb begin
      nxt = cur;
      unique case (op)
         OP_INC:  if (cur != MAX_V) nxt = cur + ONE_V;
         OP_DEC:  if (cur != MIN_V) nxt = cur - ONE_V;
         default: nxt = cur;
      endcase
   end
endmodule

// File: rtl/evctr_flags.sv
module evctr_flags #(
   parameter int unsigned CNT_W = 16
) (
   input  logic [CNT_W-1:0] cur,
   input  logic [CNT_W-1:0] lim,
   output logic             ge_lim,
   output logic             le_zero
);
   logic signed [CNT_W-1:0] cur_s;
   logic signed [CNT_W-1:0] lim_s;

   assign cur_s   = cur;
   assign lim_s   = lim;
   assign ge_lim  = (cur_s >= lim_s);
   assign le_zero = cur[CNT_W-1] | (cur == '0);
endmodule

// File: rtl/updown_event_counter.sv
module updown_event_counter
   import evctr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic             cnt_up,
   input  logic             cnt_dn,
   input  logic [CNT_W-1:0] preset,
   output logic [CNT_W-1:0] count,
   output logic             at_preset,
   output logic             at_floor
);
   localparam logic [CNT_W-1:0] MAX_V = {1'b0, {(CNT_W-1){1'b1}}};
   localparam logic [CNT_W-1:0] MIN_V = {1'b1, {(CNT_W-1){1'b0}}};

   if (CNT_W < 2) begin : g_chk_w
      $error("updown_event_counter: CNT_W must be at least 2");
   end

   logic [N_CH-1:0]  lvl;
   logic [N_CH-1:0]  rise;
   evctr_op_e        op;
   logic [CNT_W-1:0] stepped;
   logic [CNT_W-1:0] cnt_q;

   assign lvl[CH_UP] = cnt_up;
   assign lvl[CH_DN] = cnt_dn;

   evctr_edge #(.N_IN(N_CH)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .rise  (rise)
   );

   always_comb begin
      unique case ({rise[CH_DN], rise[CH_UP]})
         2'b01:   op = OP_INC;
         2'b10:   op = OP_DEC;
         default: op = OP_HOLD;
      endcase
   end

   evctr_step #(.CNT_W(CNT_W)) u_step (
      .cur (cnt_q),
      .op  (op),
      .nxt (stepped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (load) cnt_q <= preset;
      else           cnt_q <= stepped;
   end

   evctr_flags #(.CNT_W(CNT_W)) u_flags (
      .cur     (cnt_q),
      .lim     (preset),
      .ge_lim  (at_preset),
      .le_zero (at_floor)
   );

   assign count = cnt_q;

   p_clr_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));
   p_load_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load) |=> (count == $past(preset)));
   p_inc_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && rise[CH_UP] && !rise[CH_DN] && count != MAX_V)
      |=> (count == $past(count) + 1'b1));
   p_dec_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && rise[CH_DN] && !rise[CH_UP] && count != MIN_V)
      |=> (count == $past(count) - 1'b1));
   p_both_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && rise[CH_UP] && rise[CH_DN]) |=> $stable(count));
   p_sat_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && count == MAX_V && !rise[CH_DN]) |=> (count == MAX_V));
   p_sat_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && count == MIN_V && !rise[CH_UP]) |=> (count == MIN_V));
endmodule

// File: tb/updown_event_counter_tb.sv
module updown_event_counter_tb;
   localparam int   W      = 4;
   localparam time  CLK_P  = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clr = 1'b0, load = 1'b0, cnt_up = 1'b0, cnt_dn = 1'b0;
   logic [W-1:0] preset = '0;
   logic [W-1:0] count;
   logic         at_preset, at_floor;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   updown_event_counter #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load(load),
      .cnt_up(cnt_up), .cnt_dn(cnt_dn), .preset(preset),
      .count(count), .at_preset(at_preset), .at_floor(at_floor)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_cnt(input string req, input int exp);
      chk($signed(count) == exp, req, $signed(count), exp);
   endtask

   // Drive at falling edge, sample 1ns after the next rising edge.
   task automatic cyc(input bit up, input bit dn, input bit c, input bit l);
      @(negedge clk);
      cnt_up = up; cnt_dn = dn; clr = c; load = l;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      cnt_up = 1'b1; preset = 4'sd3;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk_cnt("R9 reset value", 0);
      chk(at_floor == 1'b1, "R7 floor at zero", at_floor, 1);
      chk(at_preset == 1'b0, "R6 0 below preset 3", at_preset, 0);
      cyc(1, 0, 0, 0);
      chk_cnt("R9 level high at release not counted", 0);
   endtask

   task automatic t_up();
      cyc(0, 0, 0, 0);
      cyc(1, 0, 0, 0);
      chk_cnt("R3 one rising edge", 1);
      chk(at_floor == 1'b0, "R7 positive not floor", at_floor, 0);
      cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
      chk_cnt("R3 held level counts once", 1);
      cyc(0, 0, 0, 0); cyc(1, 0, 0, 0);
      chk_cnt("R3 second pulse", 2);
   endtask

   task automatic t_down();
      cyc(0, 0, 0, 0);
      cyc(0, 1, 0, 0); chk_cnt("R4 first down", 1);
      cyc(0, 1, 0, 0); chk_cnt("R4 held down once", 1);
      cyc(0, 0, 0, 0); cyc(0, 1, 0, 0);
      cyc(0, 0, 0, 0); cyc(0, 1, 0, 0);
      chk_cnt("R4 below zero", -1);
      chk(at_floor == 1'b1, "R7 negative is floor", at_floor, 1);
   endtask

   task automatic t_both();
      cyc(0, 0, 0, 0);
      cyc(1, 1, 0, 0);
      chk_cnt("R5 simultaneous edges", -1);
   endtask

   task automatic t_ctrl();
      cyc(0, 0, 0, 0);
      preset = 4'sd5;
      cyc(1, 0, 0, 1);
      chk_cnt("R2 load ignores edge", 5);
      chk(at_preset == 1'b1, "R6 equal to preset", at_preset, 1);
      cyc(0, 0, 0, 0);
      cyc(1, 0, 1, 1);
      chk_cnt("R1 clear beats load and edge", 0);
   endtask

   task automatic t_sat();
      cyc(0, 0, 0, 0);
      preset = 4'sd6;
      cyc(0, 0, 0, 1);
      cyc(1, 0, 0, 0); chk_cnt("R8 reach max", 7);
      cyc(0, 0, 0, 0); cyc(1, 0, 0, 0);
      chk_cnt("R8 saturate at max", 7);
      preset = -4'sd7;
      cyc(0, 0, 0, 1);
      cyc(0, 1, 0, 0); chk_cnt("R8 reach min", -8);
      cyc(0, 0, 0, 0); cyc(0, 1, 0, 0);
      chk_cnt("R8 saturate at min", -8);
      #1;
      chk(at_preset == 1'b0, "R6 -8 below preset -7", at_preset, 0);
      preset = -4'sd8; #1;
      chk(at_preset == 1'b1, "R6 -8 equals preset -8", at_preset, 1);
   endtask

   initial begin : watchdog
      #(CLK_P * 5000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_up();
      t_down();
      t_both();
      t_ctrl();
      t_sat();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule